// File: doc/BRIEF.md
# Serial Loader for Static LCD Segment Drivers

This block is the host side of a link to one or more static (non-multiplexed) LCD segment driver devices. All devices share one serial clock line and one serial data line. Each device has its own latch-enable line. A client hands over a device index and a 20-bit pattern through a valid/ready handshake. In that pattern a 1 means the segment should be visible. The block raises the enable of the addressed device and sends a 21-bit frame: a start bit of 1, then the inverted segment bits for outputs 1 to 20 in that order. Once the frame is finished it drops the enable and pulses a completion flag.

Each clock-high phase and each clock-low phase lasts `PHASE_CYC` system cycles. This keeps the serial rate within the slow minimum pulse widths of such drivers, for example 5 µs per phase. The data line changes only on the edges where the serial clock falls, so it is steady through every high phase. An index at or beyond `N_DEV` is taken off the handshake and dropped, and no line moves.

Top module: `lcd_serial_host`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `req_ready` is 1 and `ser_clk`, `ser_data`, every bit of `dev_en` and `done` are 0.
- R2: During a frame exactly one enable bit is high, bit `i` for device index `i`. `ser_clk` is never high while all enables are low.
- R3: The first bit of each frame, sampled while `ser_clk` is high, is 1.
- R4: After the start bit come 20 bits for segment outputs 1 through 20 in that order. Output k is taken from `req_seg[k-1]`.
- R5: Each transmitted segment bit is the inverse of the requested bit, so a requested 1 (visible) is sent as 0.
- R6: `ser_data` holds its value for every cycle in which `ser_clk` is high. It changes only in a cycle where `ser_clk` is low.
- R7: Each high phase and each low phase of `ser_clk` inside a frame lasts exactly `PHASE_CYC` system cycles, and a frame has exactly 21 clock pulses.
- R8: The enable line is high for exactly `PHASE_CYC` cycles before the first rising edge of `ser_clk`.
- R9: The enable line falls exactly `PHASE_CYC` cycles after the last falling edge of `ser_clk`, with `ser_clk` low throughout that interval.
- R10: A request with `req_dev >= N_DEV` completes the handshake while `req_ready` stays high. It causes no change on `ser_clk`, `ser_data` or `dev_en` and no `done` pulse.
- R11: `req_ready` is 0 from the cycle after a valid request is accepted until the cycle in which the enable falls. A request presented while `req_ready` is 0 is not taken.
- R12: `done` is high for exactly one cycle, namely the first cycle in which the enable is back to 0 after a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_dev | input | DEV_W | Index of the target device |
| req_seg | input | SEG_W | Segment pattern, 1 = visible, bit 0 = output 1 |
| ser_clk | output | 1 | Shared serial clock |
| ser_data | output | 1 | Shared serial data |
| dev_en | output | N_DEV | Per-device latch enable |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The scoreboard rebuilds every frame from the line activity, so a design that sends bits in reverse output order, forgets to invert them, or drops the start bit produces a frame that does not match. Phase lengths are measured at the lead-in, in every high and low phase, and at the trail-out. An off-by-one in the phase counter, or an enable that drops together with the last falling clock edge, shows up as a wrong run length. The bench holds `req_valid` high while the block is busy, which would create an extra frame if the busy gate leaked. It also sends an index one past the last device; a design that wrapped that index onto a real device would raise an enable or pulse `done`.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } host_state_t;

  // index check done in 32-bit space so a power-of-two device count does not wrap
  function automatic logic idx_in_range(input int unsigned idx, input int unsigned n);
    return idx < n;
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int PHASE_CYC = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic phase_end
);
  localparam int CNT_W = (PHASE_CYC > 2) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign phase_end = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || phase_end || !run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/lcd_frame_shifter.sv
module lcd_frame_shifter #(
  parameter int SEG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] seg_on,
  input  logic             shift,
  output logic             bit_out,
  output logic             last_bit
);
  localparam int FRAME_W = SEG_W + 1;
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  // start bit on top, then output 1..SEG_W going down, each bit inverted
  function automatic logic [FRAME_W-1:0] make_frame(input logic [SEG_W-1:0] s);
    logic [FRAME_W-1:0] f;
    f[FRAME_W-1] = 1'b1;
    for (int k = 0; k < SEG_W; k++) begin
      f[FRAME_W-2-k] = ~s[k];
    end
    return f;
  endfunction

  logic [FRAME_W-1:0] sreg;
  logic [BIT_W-1:0]   left;

  assign bit_out  = sreg[FRAME_W-1];
  assign last_bit = (left == BIT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= make_frame(seg_on);
      left <= BIT_W'(FRAME_W);
    end else if (shift) begin
      sreg <= {sreg[FRAME_W-2:0], 1'b0};
      if (left != '0) left <= left - 1'b1;
    end
  end

  assert_start_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bit_out);
  assert_no_shift_past_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> left != '0);
endmodule

// File: rtl/lcd_serial_host.sv
module lcd_serial_host
  import lcd_host_pkg::*;
#(
  parameter int N_DEV     = 3,
  parameter int SEG_W     = 20,
  parameter int PHASE_CYC = 625,
  localparam int DEV_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [SEG_W-1:0] req_seg,
  output logic             ser_clk,
  output logic             ser_data,
  output logic [N_DEV-1:0] dev_en,
  output logic             done
);

  host_state_t      state;
  logic             clk_q, fin_q, done_q;
  logic [N_DEV-1:0] en_q, en_sel;

  // named events for the assertions
  logic accept, dev_ok, load, phase_end, shift, last_bit, bit_out;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign dev_ok    = idx_in_range(32'(req_dev), N_DEV);
  assign load      = accept && dev_ok;
  assign shift     = (state == ST_HIGH) && phase_end;

  for (genvar i = 0; i < N_DEV; i++) begin : g_sel
    assign en_sel[i] = (req_dev == DEV_W'(i));
  end

  lcd_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (load),
    .run       (state != ST_IDLE),
    .phase_end (phase_end)
  );

  lcd_frame_shifter #(.SEG_W(SEG_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .seg_on   (req_seg),
    .shift    (shift),
    .bit_out  (bit_out),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      clk_q  <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      en_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (load) begin
            state <= ST_LEAD;
            en_q  <= en_sel;
            fin_q <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (phase_end) begin
            state <= ST_HIGH;
            clk_q <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            state <= ST_LOW;
            clk_q <= 1'b0;
            fin_q <= last_bit;
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            if (fin_q) begin
              state  <= ST_IDLE;
              en_q   <= '0;
              done_q <= 1'b1;
            end else begin
              state <= ST_HIGH;
              clk_q <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk  = clk_q;
  assign ser_data = bit_out;
  assign dev_en   = en_q;
  assign done     = done_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ser_clk && dev_en == '0));
  assert_one_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_en));
  assert_clk_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> dev_en != '0);
  assert_data_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  assert_edge_on_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk != $past(ser_clk)) |-> $past(phase_end));
  assert_en_fall_clk_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_en) != '0 && dev_en == '0) |-> (!ser_clk && !$past(ser_clk)));
  assert_bad_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dev_ok) |=> (req_ready && dev_en == '0 && !done));
  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !req_ready);
  assert_done_after_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dev_en == '0 && $past(dev_en) != '0));
endmodule

// File: tb/lcd_serial_host_tb.sv
module lcd_serial_host_tb;
  localparam int N_DEV = 3;
  localparam int SEG_W = 20;
  localparam int P     = 4;
  localparam int DEV_W = 2;
  localparam int FW    = SEG_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [DEV_W-1:0] req_dev = '0;
  logic [SEG_W-1:0] req_seg = '0;
  logic ser_clk, ser_data, done;
  logic [N_DEV-1:0] dev_en;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int            q_dev[$];
  logic [FW-1:0] q_frame[$];

  always #4 clk = ~clk;

  lcd_serial_host #(.N_DEV(N_DEV), .SEG_W(SEG_W), .PHASE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_seg(req_seg), .ser_clk(ser_clk), .ser_data(ser_data),
    .dev_en(dev_en), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected frame: index 0 is the first bit on the wire
  function automatic logic [FW-1:0] expect_frame(input logic [SEG_W-1:0] s);
    logic [FW-1:0] f;
    f[0] = 1'b1;
    for (int k = 1; k <= SEG_W; k++) f[k] = !s[k-1];
    return f;
  endfunction

  task automatic send(input int dev, input logic [SEG_W-1:0] seg, input bit hold_busy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_dev   = DEV_W'(dev);
    req_seg   = seg;
    @(negedge clk);
    if (dev < N_DEV) begin
      q_dev.push_back(dev);
      q_frame.push_back(expect_frame(seg));
      chk(!req_ready, "R11", "ready after accept", req_ready, 0);
      if (hold_busy) begin
        req_seg = ~seg;
        for (int i = 0; i < 6; i++) @(negedge clk);
      end
      req_valid = 1'b0;
    end else begin
      req_valid = 1'b0;
      chk(req_ready, "R10", "ready after bad index", req_ready, 1);
      for (int i = 0; i < 3 * P; i++) begin
        @(negedge clk);
        if (dev_en != '0 || ser_clk || ser_data || done)
          chk(1'b0, "R10", "line moved on bad index",
              {dev_en, ser_clk, ser_data, done}, 0);
      end
      chk(dev_en == '0 && !ser_clk && !ser_data && !done, "R10", "quiet after bad index",
          {dev_en, ser_clk, ser_data, done}, 0);
    end
  endtask

  // monitor / scoreboard
  initial begin : monitor
    logic pclk;
    logic [N_DEV-1:0] pen;
    logic [FW-1:0] got;
    int run, nbits;
    logic cur;
    pclk = 0; pen = '0; got = '0; run = 0; nbits = 0; cur = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (pen == '0 && dev_en != '0) begin
        chk($onehot(dev_en), "R2", "enable one-hot", dev_en, 0);
        nbits = 0; got = '0; run = 1;
      end else if (pen != '0 && dev_en == '0) begin
        chk(run == P, "R9", "trail length", run, P);
        chk(!ser_clk, "R9", "clk low at enable fall", ser_clk, 0);
        chk(done, "R12", "done with enable fall", done, 1);
        chk(req_ready, "R11", "ready at enable fall", req_ready, 1);
        chk(nbits == FW, "R7", "pulse count", nbits, FW);
        if (q_dev.size() == 0) begin
          chk(1'b0, "R11", "frame with no request", got, 0);
        end else begin
          int d;
          logic [FW-1:0] ef;
          d  = q_dev.pop_front();
          ef = q_frame.pop_front();
          chk(pen == N_DEV'(1 << d), "R2", "enable of addressed device", pen, 1 << d);
          chk(got[0] == 1'b1, "R3", "start bit", got[0], 1);
          chk(got == ef, "R4 R5", "frame order and polarity", got, ef);
        end
        run = 1;
      end else if (dev_en != '0 && ser_clk != pclk) begin
        if (ser_clk) begin
          if (nbits == 0) chk(run == P, "R8", "lead before first pulse", run, P);
          else            chk(run == P, "R7", "low phase", run, P);
          chk(!req_ready, "R11", "ready while busy", req_ready, 0);
          cur = ser_data;
          if (nbits < FW) got[nbits] = ser_data;
          nbits++;
        end else begin
          chk(run == P, "R7", "high phase", run, P);
        end
        run = 1;
      end else begin
        run++;
        if (ser_clk && ser_data != cur)
          chk(1'b0, "R6", "data moved in high phase", ser_data, cur);
        if (done) chk(1'b0, "R12", "stray done", done, 0);
      end
      if (ser_clk && dev_en == '0) chk(1'b0, "R2", "clk without enable", ser_clk, 0);
      pclk = ser_clk;
      pen  = dev_en;
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "WDOG", "watchdog expired", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(req_ready && dev_en == '0 && !ser_clk && !ser_data && !done, "R1", "reset state",
        {req_ready, dev_en, ser_clk, ser_data, done}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && dev_en == '0 && !ser_clk && !ser_data && !done, "R1", "idle after reset",
        {req_ready, dev_en, ser_clk, ser_data, done}, 5'b10000);
    send(0, 20'h00000, 1'b0);
    send(1, 20'hFFFFF, 1'b0);
    send(2, 20'hA5C3F, 1'b1);
    send(3, 20'h12345, 1'b0);
    send(0, 20'h00001, 1'b0);
    send(2, 20'h80000, 1'b0);
    send(1, 20'h5A5A5, 1'b1);
    @(negedge clk);
    while (!req_ready || q_dev.size() != 0) @(negedge clk);
    repeat (2 * P) @(negedge clk);
    chk(req_ready && dev_en == '0 && !ser_clk && !ser_data && !done, "R1", "idle at end",
        {req_ready, dev_en, ser_clk, ser_data, done}, 5'b10000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule